// File: doc/BRIEF.md
# Float Bit-Manipulation Execution Unit

This unit serves a small microcoded single-precision coprocessor. It executes the operations that need no rounding datapath: absolute value, register copy, a flags-driven select, sign transfer from a second operand, greater-than and equality compares that yield a float 1.0 or 0.0, and the magic-constant seed for a reciprocal square root. Each request carries a 4-bit opcode, two IEEE-754 single operands, and a flags word. Each response carries a 32-bit result, the fixed latency of the operation, and an unsupported marker.

Requests and responses are valid/ready streams. A request transfers on a rising edge where `in_valid` and `in_ready` are both high. A response transfers where `out_valid` and `out_ready` are both high. While a response waits with `out_ready` low, it stays frozen on the outputs. Behind it the two-stage pipeline fills, and then it lowers `in_ready`. Responses leave in request order, none dropped and none repeated. Arithmetic opcodes (add, subtract, multiply, the two conversions, vector output, sine, cosine) go through the pipeline as well. They come back flagged unsupported, with a zero result and the latency that the full coprocessor gives them.

Top module: `fbx_unit`

## Requirements
- R1: Once reset is released, `out_valid` is low and `in_ready` is high until a request is accepted.
- R2: Opcode 4 (absolute value) returns A with bit 31 cleared and every other bit unchanged.
- R3: Opcode 12 (copy) returns A bit for bit.
- R4: Opcode 13 (select) returns A when any bit of the flags word is set, and B when the flags word is zero.
- R5: Opcode 14 (sign transfer) returns A with bit 31 inverted when B is numerically below zero, and A unchanged otherwise. Negative zero does not count as below zero.
- R6: Opcode 10 (greater-than) returns 0x3F800000 when A is numerically greater than B, and 0x00000000 otherwise. +0 and -0 compare as equal. Operands are finite.
- R7: Opcode 11 (equality) returns 0x3F800000 when A equals B numerically, with +0 equal to -0, and 0x00000000 otherwise.
- R8: Opcode 15 (rsqrt seed) returns 0x5F3759DF minus (A logically shifted right by one), modulo 2^32.
- R9: Opcodes 1, 2, 3, 5, 6, 7, 8 and 9 return `out_unsup`=1, a zero result, and latencies 5, 5, 7, 2, 3, 0, 4 and 4 respectively. Opcode 0 (no-op) returns `out_unsup`=0, a zero result, and latency 0.
- R10: Opcodes 4 and 10 through 15 report `out_unsup`=0 and `out_latency`=2.
- R11: With `out_ready` held high, a request accepted on a rising edge has its response on the outputs just after the next rising edge, which is the second clock cycle counting the accepting one.
- R12: While `out_valid` is high and `out_ready` is low, all response outputs hold steady. Whenever `out_valid` is low, `in_ready` is high. Responses come out in acceptance order with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Opcode |
| in_a | input | 32 | Operand A, IEEE-754 single |
| in_b | input | 32 | Operand B, IEEE-754 single |
| in_flags | input | 32 | Flags word for select |
| out_valid | output | 1 | Response valid |
| out_ready | input | 1 | Consumer takes the response |
| out_result | output | 32 | Result word |
| out_latency | output | 4 | Fixed latency of the executed opcode |
| out_unsup | output | 1 | Opcode not executed by this unit |

## Verification
The pipeline registers hold the whole response, so a corrupted stage valid bit or payload surfaces on the outputs within two cycles. A lost valid bit shows as a missing response and a desynchronised queue at the next transfer. A stuck one shows as a duplicated response. A wrong magnitude key in the compare shows up only for particular operand pairs, such as mixed signs, signed zeros and denormals. For that reason the operand sweep crosses every value of a twelve-value set with every other, under every opcode. A stage that captures data while stalled changes the held result on the very next cycle.

// File: rtl/fbx_pkg.sv
package fbx_pkg;

  localparam int FX_DW   = 32;
  localparam int FX_LW   = 4;
  localparam int FX_STG  = 2;

  localparam logic [FX_DW-1:0] FX_ONE  = 32'h3F80_0000;
  localparam logic [FX_DW-1:0] FX_SEED = 32'h5F37_59DF;

  typedef enum logic [3:0] {
    FX_NOP  = 4'd0,  FX_ADD  = 4'd1,  FX_SUB  = 4'd2,  FX_MUL  = 4'd3,
    FX_ABS  = 4'd4,  FX_F2I  = 4'd5,  FX_I2F  = 4'd6,  FX_VOUT = 4'd7,
    FX_SIN  = 4'd8,  FX_COS  = 4'd9,  FX_GT   = 4'd10, FX_EQ   = 4'd11,
    FX_CPY  = 4'd12, FX_SEL  = 4'd13, FX_SGN  = 4'd14, FX_RSQ  = 4'd15
  } fx_op_e;

  typedef struct packed {
    logic [3:0]       op;
    logic             unsup;
    logic [FX_LW-1:0] lat;
    logic [FX_DW-1:0] res;
  } fx_pay_t;

  function automatic logic [FX_LW-1:0] fx_latency(input logic [3:0] op);
    case (op)
      FX_ADD, FX_SUB: fx_latency = 4'd5;
      FX_MUL:         fx_latency = 4'd7;
      FX_F2I:         fx_latency = 4'd2;
      FX_I2F:         fx_latency = 4'd3;
      FX_SIN, FX_COS: fx_latency = 4'd4;
      FX_NOP, FX_VOUT: fx_latency = 4'd0;
      default:        fx_latency = FX_LW'(FX_STG);
    endcase
  endfunction

  function automatic logic fx_is_unsup(input logic [3:0] op);
    case (op)
      FX_ADD, FX_SUB, FX_MUL, FX_F2I, FX_I2F, FX_VOUT, FX_SIN, FX_COS:
        fx_is_unsup = 1'b1;
      default: fx_is_unsup = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fbx_cmp.sv
module fbx_cmp
  import fbx_pkg::*;
#(
  parameter int DW = FX_DW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          gt,
  output logic          eq
);
  localparam int SB = DW - 1;
  localparam logic [DW-1:0] TOPBIT = {1'b1, {(DW-1){1'b0}}};

  logic          zero_pair;
  logic [DW-1:0] key_a, key_b;

  // Monotonic key: positives get the top bit set, negatives are inverted.
  always_comb begin
    zero_pair = ~|a[SB-1:0] & ~|b[SB-1:0];
    key_a     = a[SB] ? ~a : (a | TOPBIT);
    key_b     = b[SB] ? ~b : (b | TOPBIT);
    eq        = zero_pair | (a == b);
    gt        = ~zero_pair & (key_a > key_b);
  end

endmodule

// File: rtl/fbx_ops.sv
module fbx_ops
  import fbx_pkg::*;
#(
  parameter int DW  = FX_DW,
  parameter int FLW = 32
) (
  input  logic [3:0]     op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [FLW-1:0] flags,
  output fx_pay_t        pay
);
  localparam int SB = DW - 1;

  logic a_gt_b, a_eq_b;
  logic b_neg;

  fbx_cmp #(.DW(DW)) i_cmp (.a(a), .b(b), .gt(a_gt_b), .eq(a_eq_b));

  always_comb begin
    b_neg     = b[SB] & |b[SB-1:0];
    pay.op    = op;
    pay.lat   = fx_latency(op);
    pay.unsup = fx_is_unsup(op);
    pay.res   = '0;
    case (op)
      FX_ABS: pay.res = {1'b0, a[SB-1:0]};
      FX_CPY: pay.res = a;
      FX_SEL: pay.res = (|flags) ? a : b;
      FX_SGN: pay.res = {a[SB] ^ b_neg, a[SB-1:0]};
      FX_GT:  pay.res = a_gt_b ? FX_ONE : '0;
      FX_EQ:  pay.res = a_eq_b ? FX_ONE : '0;
      FX_RSQ: pay.res = FX_SEED - (a >> 1);
      default: pay.res = '0;
    endcase
  end

endmodule

// File: rtl/fbx_stage.sv
module fbx_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         i_valid,
  output logic         i_ready,
  input  logic [W-1:0] i_data,
  output logic         o_valid,
  input  logic         o_ready,
  output logic [W-1:0] o_data
);
  assign i_ready = ~o_valid | o_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
    end else if (i_ready) begin
      o_valid <= i_valid;
      if (i_valid) o_data <= i_data;
    end
  end

endmodule

// File: rtl/fbx_unit.sv
module fbx_unit
  import fbx_pkg::*;
#(
  parameter int STAGES = FX_STG,
  parameter int FLW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [FX_DW-1:0] in_a,
  input  logic [FX_DW-1:0] in_b,
  input  logic [FLW-1:0]   in_flags,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [FX_DW-1:0] out_result,
  output logic [FX_LW-1:0] out_latency,
  output logic             out_unsup
);
  localparam int PW = $bits(fx_pay_t);

  fx_pay_t       head, tail;
  logic [3:0]    tail_op;
  logic [PW-1:0] dat [STAGES+1];
  logic          vld [STAGES+1];
  logic          rdy [STAGES+1];

  fbx_ops #(.DW(FX_DW), .FLW(FLW)) i_ops (
    .op(in_op), .a(in_a), .b(in_b), .flags(in_flags), .pay(head)
  );

  assign dat[0]       = head;
  assign vld[0]       = in_valid;
  assign in_ready     = rdy[0];
  assign rdy[STAGES]  = out_ready;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    fbx_stage #(.W(PW)) i_stage (
      .clk(clk), .rst_n(rst_n),
      .i_valid(vld[g]), .i_ready(rdy[g]), .i_data(dat[g]),
      .o_valid(vld[g+1]), .o_ready(rdy[g+1]), .o_data(dat[g+1])
    );
  end

  assign tail        = fx_pay_t'(dat[STAGES]);
  assign tail_op     = tail.op;
  assign out_valid   = vld[STAGES];
  assign out_result  = tail.res;
  assign out_latency = tail.lat;
  assign out_unsup   = tail.unsup;

endmodule

// File: rtl/fbx_unit_chk.sv
module fbx_unit_chk
  import fbx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [FX_DW-1:0] out_result,
  input logic [FX_LW-1:0] out_latency,
  input logic             out_unsup,
  input logic [3:0]       tail_op
);

  a_r12_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
                                && $stable(out_latency) && $stable(out_unsup));

  a_r12_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r9_unsup_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unsup |-> out_result == '0);

  a_r6_gt_bool: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && tail_op == FX_GT |-> out_result == '0 || out_result == FX_ONE);

  a_r7_eq_bool: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && tail_op == FX_EQ |-> out_result == '0 || out_result == FX_ONE);

  a_r2_abs_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && tail_op == FX_ABS |-> !out_result[FX_DW-1]);

  a_r10_lat_two: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_unsup && tail_op != FX_NOP |-> out_latency == 4'd2);

endmodule

bind fbx_unit fbx_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_latency(out_latency),
  .out_unsup(out_unsup), .tail_op(tail_op)
);

// File: tb/test_fbx_unit.sv
module test_fbx_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0, in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic [3:0]  out_latency;
  logic        out_unsup;

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] vals [12];
  logic [31:0] flg  [3];

  logic [31:0] q_res [$];
  logic [3:0]  q_lat [$];
  logic        q_uns [$];
  logic [3:0]  q_op  [$];
  int          q_t   [$];

  localparam int NV = 12;
  localparam int NALL = NV * NV * 16 * 3;

  always #10 clk = ~clk;

  fbx_unit i_fbx_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_latency(out_latency), .out_unsup(out_unsup)
  );

  function automatic real f2r(input logic [31:0] x);
    int  e;
    real m, r;
    e = int'(x[30:23]);
    m = real'(x[22:0]);
    if (e == 0) r = m * (2.0 ** (-149));
    else        r = (1.0 + m / 8388608.0) * (2.0 ** (e - 127));
    return x[31] ? -r : r;
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd4:  return "R2";
      4'd12: return "R3";
      4'd13: return "R4";
      4'd14: return "R5";
      4'd10: return "R6";
      4'd11: return "R7";
      4'd15: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic expect_of(input logic [3:0] op, input logic [31:0] a, b, f,
                           output logic [31:0] res, output logic [3:0] lat,
                           output logic uns);
    res = 32'h0; lat = 4'd2; uns = 1'b0;
    case (op)
      4'd0: lat = 4'd0;
      4'd1, 4'd2: begin uns = 1'b1; lat = 4'd5; end
      4'd3: begin uns = 1'b1; lat = 4'd7; end
      4'd5: begin uns = 1'b1; lat = 4'd2; end
      4'd6: begin uns = 1'b1; lat = 4'd3; end
      4'd7: begin uns = 1'b1; lat = 4'd0; end
      4'd8, 4'd9: begin uns = 1'b1; lat = 4'd4; end
      4'd4:  res = a & 32'h7FFF_FFFF;
      4'd12: res = a;
      4'd13: res = (f != 0) ? a : b;
      4'd14: res = (f2r(b) < 0.0) ? (a ^ 32'h8000_0000) : a;
      4'd10: res = (f2r(a) > f2r(b)) ? 32'h3F80_0000 : 32'h0;
      4'd11: res = (f2r(a) == f2r(b)) ? 32'h3F80_0000 : 32'h0;
      default: res = 32'h5F37_59DF - {1'b0, a[31:1]};
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Runs request indices lo..hi-1; stream=1 keeps both sides always willing.
  task automatic run(input int lo, input int hi, input bit stream);
    int k = lo;
    logic [31:0] hres, er;
    logic [3:0]  hlat, el;
    logic        huns, eu, stalled;
    stalled = 1'b0;
    hres = '0; hlat = '0; huns = 1'b0;
    while (k < hi || q_res.size() != 0) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stream ? 1'b1 : (lfsr[0] | lfsr[3]);
      in_valid  = (k < hi) && (stream || lfsr[1]);
      if (k < hi) begin
        in_flags = flg[k % 3];
        in_op    = 4'((k / 3) % 16);
        in_b     = vals[(k / 48) % NV];
        in_a     = vals[k / (48 * NV)];
      end
      #1;
      if (stalled) begin
        chk(out_valid && out_result == hres && out_latency == hlat &&
            out_unsup == huns, "R12 hold", out_result, hres);
      end
      if (out_valid && out_ready) begin
        if (q_res.size() == 0) begin
          chk(1'b0, "R12 spurious response", out_result, 32'h0);
        end else begin
          er = q_res.pop_front(); el = q_lat.pop_front();
          eu = q_uns.pop_front();
          begin
            logic [3:0] eo;
            int t;
            eo = q_op.pop_front(); t = q_t.pop_front();
            chk(out_result == er, tag_of(eo), out_result, er);
            chk(out_latency == el && out_unsup == eu,
                (eu || eo == 4'd0) ? "R9 latency/unsup" : "R10 latency/unsup",
                {27'd0, out_unsup, out_latency}, {27'd0, eu, el});
            if (stream)
              chk(cyc - t == 2, "R11 timing", 32'(cyc - t), 32'd2);
          end
        end
      end
      stalled = out_valid && !out_ready;
      hres = out_result; hlat = out_latency; huns = out_unsup;
      if (in_valid && in_ready) begin
        expect_of(in_op, in_a, in_b, in_flags, er, el, eu);
        q_res.push_back(er); q_lat.push_back(el); q_uns.push_back(eu);
        q_op.push_back(in_op); q_t.push_back(cyc);
        k++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    vals[0]  = 32'h0000_0000; vals[1]  = 32'h8000_0000;
    vals[2]  = 32'h3F80_0000; vals[3]  = 32'hBF80_0000;
    vals[4]  = 32'h4000_0000; vals[5]  = 32'hC049_0FDB;
    vals[6]  = 32'h0000_0001; vals[7]  = 32'h8000_0001;
    vals[8]  = 32'h7F7F_FFFF; vals[9]  = 32'hFF7F_FFFF;
    vals[10] = 32'h3F80_0001; vals[11] = 32'h1234_5678;
    flg[0] = 32'h0; flg[1] = 32'h1; flg[2] = 32'h8000_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(!out_valid, "R1 out_valid", {31'd0, out_valid}, 32'd0);
      chk(in_ready, "R1 in_ready", {31'd0, in_ready}, 32'd1);
    end

    // Full sweep twice: once streaming, once with random back-pressure (R12).
    run(0, NALL, 1'b1);
    run(0, NALL, 1'b0);

    // Fill under stall: two accepted, third refused (R12).
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_op = 4'd12; in_a = 32'h1111_1111;
    @(negedge clk); in_a = 32'h2222_2222;
    @(negedge clk); in_a = 32'h3333_3333;
    #1 chk(!in_ready && out_valid && out_result == 32'h1111_1111,
           "R12 full stall", out_result, 32'h1111_1111);
    in_valid = 1'b0;
    @(negedge clk); out_ready = 1'b1;
    #1 chk(out_result == 32'h1111_1111, "R12 order", out_result, 32'h1111_1111);
    @(negedge clk);
    #1 chk(out_valid && out_result == 32'h2222_2222, "R12 order",
           out_result, 32'h2222_2222);
    @(negedge clk);
    #1 chk(!out_valid, "R12 no duplicate", {31'd0, out_valid}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule